// File: doc/BRIEF.md
# Path Ring-Oscillator Test Controller

This controller runs a wear-out delay test on one monitored pipeline path at a time. A bank of paths can each be closed into a ring oscillator. The oscillation frequency then tracks the path delay, and a shared count monitor measures it. When a test is requested, the controller first stops the pipeline clock so that no corrupt data moves while a path is out of service. It then cuts the chosen path away from its neighbours and closes its feedback loop. An extra inverter is added to the loop only when the path does not invert on its own. The controller steers the path output to the monitor and starts the count. When the monitor finishes, the controller opens the loop and deselects the monitor. It releases the clock only after that.

Tests are meant to run during idle time, start-up or shutdown, because the pipeline does no work while a test is in progress. Requests are taken only when the controller is idle. The path number is captured when a request is taken, and a number outside the bank is refused with a one-cycle error pulse. Each test register is modelled as a mux driven by its loop-select bit.

Top module: `ring_osc_test_ctrl`

## Requirements
- R1: After reset, `clk_en` is 1, and `loop_sel`, `fb_invert`, `mon_sel`, `mon_start` and `req_err` are all 0.
- R2: In the cycle after a request is accepted, `clk_en` is 0 and every bit of `loop_sel` is still 0. This is a one-cycle settle step. While any loop bit is set, `clk_en` is 0.
- R3: In the cycle after the settle step, `loop_sel` has exactly one bit set, at the captured index. Bit i of `loop_sel` is path i. In the same cycle `mon_sel` equals that index.
- R4: While a loop is closed, `fb_invert` is 1 exactly when the selected path's `path_inverting` bit is 0.
- R5: `mon_start` is high for exactly one cycle: the first cycle after the loop closes.
- R6: After `mon_start`, the loop, `mon_sel` and `fb_invert` stay unchanged until `mon_done` is sampled high.
- R7: The cycle after `mon_done` is taken, `loop_sel`, `mon_sel` and `fb_invert` are 0 and `clk_en` is still 0. `clk_en` returns to 1 one cycle later.
- R8: A `test_req` is ignored unless the controller is idle. The index is captured when the request is accepted, so later changes on `path_idx` do not move the selected path.
- R9: A request whose index is NUM_PATHS or more is refused. `req_err` is 1 for one cycle, `clk_en` stays 1 and no loop closes.
- R10: `mon_done` has no effect before the measurement phase. When it is seen while idle or during the settle step, the sequence and outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| test_req | input | 1 | Request to test one path |
| path_idx | input | IDX_W | Number of the path to test |
| path_inverting | input | NUM_PATHS | 1 where a path inverts end to end |
| mon_done | input | 1 | Count monitor has finished |
| clk_en | output | 1 | Pipeline clock-gate enable (0 holds the clock low) |
| loop_sel | output | NUM_PATHS | Per-path loop-close control for the test registers |
| fb_invert | output | 1 | Adds the extra inverter to the feedback loop |
| mon_sel | output | IDX_W | Select of the mux that feeds the count monitor |
| mon_start | output | 1 | One-cycle start pulse to the monitor |
| req_err | output | 1 | One-cycle pulse when an index is refused |

## Verification
The assertions assume the following about the inputs:
- `mon_done` arrives only as an answer to a measurement.
- `path_inverting` is static for as long as a path is looped.

Apart from that, the assertions rely only on sequencing the controller produces itself: one-hot loop selection, a gated clock whenever a loop is closed, a single-cycle start pulse, and the clock re-enabling only after every loop is open. The stimulus keeps the inversion flags fixed for the whole of each test. It drives every input half a cycle away from the sampling edge. It also deliberately raises `test_req`, `mon_done` and `path_idx` changes in phases where they must be ignored.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_HALT    = 3'd1,
        ST_LOOP    = 3'd2,
        ST_MEAS    = 3'd3,
        ST_RESTORE = 3'd4
    } ptc_state_t;

    function automatic logic idx_in_range(input int unsigned idx, input int unsigned limit);
        return idx < limit;
    endfunction

    function automatic logic loop_closed(input ptc_state_t st);
        return (st == ST_LOOP) || (st == ST_MEAS);
    endfunction

endpackage

// File: rtl/ptc_sequencer.sv
module ptc_sequencer
    import ptc_pkg::*;
#(
    parameter int unsigned NUM_PATHS = 6,
    parameter int unsigned IDX_W     = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             test_req,
    input  logic [IDX_W-1:0] path_idx,
    input  logic             mon_done,
    output ptc_state_t       state,
    output logic [IDX_W-1:0] idx_q,
    output logic             mon_start,
    output logic             req_err
);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            idx_q     <= '0;
            mon_start <= 1'b0;
            req_err   <= 1'b0;
        end else begin
            mon_start <= 1'b0;
            req_err   <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (test_req) begin
                        if (idx_in_range(32'(path_idx), NUM_PATHS)) begin
                            idx_q <= path_idx;
                            state <= ST_HALT;
                        end else begin
                            req_err <= 1'b1;
                        end
                    end
                end
                ST_HALT: state <= ST_LOOP;
                ST_LOOP: begin
                    state     <= ST_MEAS;
                    mon_start <= 1'b1;
                end
                ST_MEAS: begin
                    if (mon_done) state <= ST_RESTORE;
                end
                ST_RESTORE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R5
    start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        mon_start |=> !mon_start);

    // R9
    err_idle_chk: assert property (@(posedge clk) disable iff (rst)
        req_err |-> (state == ST_IDLE));

endmodule

// File: rtl/ptc_loop_steer.sv
module ptc_loop_steer #(
    parameter int unsigned NUM_PATHS = 6,
    parameter int unsigned IDX_W     = 3
) (
    input  logic                 active,
    input  logic [IDX_W-1:0]     idx,
    input  logic [NUM_PATHS-1:0] path_inverting,
    output logic [NUM_PATHS-1:0] loop_sel,
    output logic                 fb_invert,
    output logic [IDX_W-1:0]     mon_sel
);

    for (genvar g = 0; g < NUM_PATHS; g++) begin : g_path
        assign loop_sel[g] = active && (idx == IDX_W'(g));
    end

    assign fb_invert = |(loop_sel & ~path_inverting);
    assign mon_sel   = active ? idx : '0;

    // R3
    loop_onehot_chk: assert final ($onehot0(loop_sel));

endmodule

// File: rtl/ring_osc_test_ctrl.sv
module ring_osc_test_ctrl
    import ptc_pkg::*;
#(
    parameter int unsigned NUM_PATHS = 6,
    localparam int unsigned IDX_W    = (NUM_PATHS > 1) ? $clog2(NUM_PATHS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 test_req,
    input  logic [IDX_W-1:0]     path_idx,
    input  logic [NUM_PATHS-1:0] path_inverting,
    input  logic                 mon_done,
    output logic                 clk_en,
    output logic [NUM_PATHS-1:0] loop_sel,
    output logic                 fb_invert,
    output logic [IDX_W-1:0]     mon_sel,
    output logic                 mon_start,
    output logic                 req_err
);

    ptc_state_t       state;
    logic [IDX_W-1:0] idx_q;

    ptc_sequencer #(.NUM_PATHS(NUM_PATHS), .IDX_W(IDX_W)) i_seq (
        .clk       (clk),
        .rst       (rst),
        .test_req  (test_req),
        .path_idx  (path_idx),
        .mon_done  (mon_done),
        .state     (state),
        .idx_q     (idx_q),
        .mon_start (mon_start),
        .req_err   (req_err)
    );

    ptc_loop_steer #(.NUM_PATHS(NUM_PATHS), .IDX_W(IDX_W)) i_steer (
        .active         (loop_closed(state)),
        .idx            (idx_q),
        .path_inverting (path_inverting),
        .loop_sel       (loop_sel),
        .fb_invert      (fb_invert),
        .mon_sel        (mon_sel)
    );

    assign clk_en = (state == ST_IDLE);

    // R2
    gated_while_looped_chk: assert property (@(posedge clk) disable iff (rst)
        (|loop_sel) |-> !clk_en);

    // R7
    ungate_after_open_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_en) |-> (loop_sel == '0) && ($past(loop_sel) == '0));

    // R6
    hold_loop_chk: assert property (@(posedge clk) disable iff (rst)
        ((|loop_sel) && !mon_done && !mon_start && $past(|loop_sel)) |=> $stable(loop_sel));

    // R9
    refuse_keeps_clock_chk: assert property (@(posedge clk) disable iff (rst)
        req_err |-> clk_en && (loop_sel == '0));

endmodule

// File: tb/test_ring_osc_test_ctrl.sv
module test_ring_osc_test_ctrl;

    localparam int NP = 6;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic          test_req;
    logic [IW-1:0] path_idx;
    logic [NP-1:0] path_inverting;
    logic          mon_done;
    logic          clk_en;
    logic [NP-1:0] loop_sel;
    logic          fb_invert;
    logic [IW-1:0] mon_sel;
    logic          mon_start;
    logic          req_err;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    ring_osc_test_ctrl #(.NUM_PATHS(NP)) i_ring_osc_test_ctrl (
        .clk(clk), .rst(rst), .test_req(test_req), .path_idx(path_idx),
        .path_inverting(path_inverting), .mon_done(mon_done), .clk_en(clk_en),
        .loop_sel(loop_sel), .fb_invert(fb_invert), .mon_sel(mon_sel),
        .mon_start(mon_start), .req_err(req_err)
    );

    // entry: {index[12:10], inverting mask[9:4], extra measure cycles[3:0]}
    localparam logic [12:0] VEC [6] = '{
        {3'd0, 6'b000001, 4'd0},
        {3'd0, 6'b000000, 4'd2},
        {3'd5, 6'b100000, 4'd1},
        {3'd5, 6'b011111, 4'd3},
        {3'd3, 6'b110111, 4'd0},
        {3'd1, 6'b000010, 4'd5}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_one(input int idx, input logic [NP-1:0] inv, input int extra);
        @(negedge clk);
        path_inverting = inv;
        path_idx = IW'(idx);
        test_req = 1'b1;
        @(negedge clk);                              // settle step
        check(clk_en == 1'b0, "R2 clk_en", int'(clk_en), 0);
        check(loop_sel == '0, "R2 loop_sel", int'(loop_sel), 0);
        path_idx = IW'((idx + 1) % NP);              // R8: late change and repeated request
        @(negedge clk);                              // loop closed
        check(loop_sel == NP'(1 << idx), "R3 loop_sel", int'(loop_sel), 1 << idx);
        check(mon_sel == IW'(idx), "R3 mon_sel", int'(mon_sel), idx);
        check(fb_invert == !inv[idx], "R4 fb_invert", int'(fb_invert), int'(!inv[idx]));
        check(mon_start == 1'b0, "R5 early start", int'(mon_start), 0);
        @(negedge clk);                              // first measure cycle
        check(mon_start == 1'b1, "R5 start", int'(mon_start), 1);
        for (int k = 0; k < extra; k++) begin
            @(negedge clk);
            check(mon_start == 1'b0, "R5 single pulse", int'(mon_start), 0);
            check(loop_sel == NP'(1 << idx), "R6 R8 loop held", int'(loop_sel), 1 << idx);
        end
        mon_done = 1'b1;
        @(negedge clk);                              // restore cycle
        mon_done = 1'b0;
        test_req = 1'b0;
        check(loop_sel == '0 && mon_sel == '0 && fb_invert == 1'b0, "R7 loop open",
              int'(loop_sel), 0);
        check(clk_en == 1'b0, "R7 clock still gated", int'(clk_en), 0);
        @(negedge clk);
        check(clk_en == 1'b1, "R7 clock released", int'(clk_en), 1);
    endtask

    initial begin
        rst = 1'b1; test_req = 1'b0; path_idx = '0; path_inverting = '0; mon_done = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(clk_en == 1'b1, "R1 clk_en", int'(clk_en), 1);
        check(loop_sel == '0 && fb_invert == 1'b0 && mon_sel == '0, "R1 steering",
              int'(loop_sel), 0);
        check(mon_start == 1'b0 && req_err == 1'b0, "R1 pulses", int'(mon_start), 0);

        foreach (VEC[i]) run_one(int'(VEC[i][12:10]), VEC[i][9:4], int'(VEC[i][3:0]));

        // R9: out-of-range index
        @(negedge clk);
        path_idx = 3'd6; test_req = 1'b1;
        @(negedge clk);
        test_req = 1'b0;
        check(req_err == 1'b1, "R9 err pulse", int'(req_err), 1);
        check(clk_en == 1'b1 && loop_sel == '0, "R9 no test", int'(loop_sel), 0);
        @(negedge clk);
        check(req_err == 1'b0, "R9 err one cycle", int'(req_err), 0);
        check(clk_en == 1'b1, "R9 still idle", int'(clk_en), 1);

        // R10: mon_done while idle, then during the settle step
        mon_done = 1'b1;
        @(negedge clk);
        check(clk_en == 1'b1 && loop_sel == '0, "R10 idle done", int'(clk_en), 1);
        path_idx = 3'd2; path_inverting = 6'b000100; test_req = 1'b1;
        @(negedge clk);                              // settle step, mon_done still high
        test_req = 1'b0;
        mon_done = 1'b0;
        @(negedge clk);
        check(loop_sel == 6'b000100, "R10 loop closes", int'(loop_sel), 4);
        check(fb_invert == 1'b0, "R4 inverting path", int'(fb_invert), 0);
        @(negedge clk);
        check(mon_start == 1'b1, "R10 measure starts", int'(mon_start), 1);
        @(negedge clk);
        check(loop_sel == 6'b000100, "R10 R6 still measuring", int'(loop_sel), 4);
        mon_done = 1'b1;
        @(negedge clk);
        mon_done = 1'b0;
        @(negedge clk);
        check(clk_en == 1'b1, "R7 final release", int'(clk_en), 1);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule